// File: doc/BRIEF.md
# Two-Common Multiplexed LCD Segment Driver

This block drives a passive LCD panel built with two common planes at 1/2 duty and 1/2 bias. It has 25 segment lines, so it can show up to 50 segments. Software writes one segment bitmap for each common plane, using a separate strobe per plane. The block then produces a three-level code on every common and segment pin (ground, half supply, full supply), and an external analog stage turns each code into a voltage. Level generation and the electrical behaviour of the glass are outside this block.

A frame has four equal slots of `SLOT_CLKS` clock cycles each; a 5 ms slot gives a 50 Hz frame. In the first half of the frame the two commons are each selected once with positive polarity. In the second half they are selected again with every full level inverted, so each pin has zero average DC across a frame. Bitmap writes go into a shadow copy, and that copy is applied only at a frame boundary, so a frame is never drawn from mixed data.

The topmost segment lines can be handed to a general-purpose port, one control bit per line. Reset, a display-off input and a clock-stop input each force every pin to ground.

Top module: `lcd_half_duty_drv`

## Requirements
- R1: While `rst` is high, every common and segment pin reads ground and both shadow bitmaps and both displayed bitmaps are cleared. The first cycle after `rst` falls is cycle 0 of slot 0.
- R2: Each pin carries a 2-bit code: 2'b00 means ground, 2'b01 means half level and 2'b10 means full level. The code 2'b11 is never produced.
- R3: Each slot lasts `SLOT_CLKS` cycles and the slots repeat in the order 0,1,2,3. Slot bit 0 selects the common: 0 selects common 1 (`com_lvl[1:0]`) and 1 selects common 2 (`com_lvl[3:2]`). Slot bit 1 gives the polarity: 0 is positive and 1 is negative.
- R4: With the display enabled, the common that is not selected sits at the half level. The selected common is at full level in a positive slot and at ground in a negative slot.
- R5: Segment line i (`seg_lvl[2i+1:2i]`) reads bit i of the selected plane's displayed bitmap. A 1 drives the level opposite to the selected common (ground against full, full against ground). A 0 drives the same level as the selected common.
- R6: `wr_plane1` loads `wr_data` into the shadow bitmap of plane 1 only, and `wr_plane2` loads it into the shadow bitmap of plane 2 only. A write to one plane leaves the other plane's picture unchanged.
- R7: A written bitmap appears on the pins from the first slot 0 that begins after the write, never earlier in the frame. The frame boundary is the edge that ends the last cycle of slot 3.
- R8: While `disp_off` is high, every pin reads ground. The timing is held at cycle 0 of slot 0, and the displayed bitmaps follow the shadow bitmaps. After release, drawing restarts at slot 0 with the latest data.
- R9: `clk_stop` behaves exactly like `disp_off`: all pins read ground, timing is held, and the shadow data is taken over.
- R10: When `port_sel[j]` is 1, segment line `NUM_SEG-NUM_SHARED+j` reads full level if `port_dout[j]` is 1 and ground if it is 0, whatever the slot and the bitmap. Blanking still forces it to ground.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also blanks the pins |
| disp_off | input | 1 | Display off: blanks the pins and holds the timing |
| clk_stop | input | 1 | Clock-stop request: blanks the pins and holds the timing |
| wr_plane1 | input | 1 | Write strobe for the plane-1 shadow bitmap |
| wr_plane2 | input | 1 | Write strobe for the plane-2 shadow bitmap |
| wr_data | input | NUM_SEG | Bitmap to write; bit i belongs to segment line i |
| port_sel | input | NUM_SHARED | Per-line handover of the top segment lines to the port |
| port_dout | input | NUM_SHARED | Port data for the handed-over lines |
| com_lvl | output | 4 | Level codes for common 1 [1:0] and common 2 [3:2] |
| seg_lvl | output | 2*NUM_SEG | Level codes, line i at [2i+1:2i] |

## Verification
The hardest case to reach is a bitmap write in the middle of a frame, because it must stay invisible until the next slot 0 even while the other plane keeps drawing. The bench synchronises to the frame through `disp_off`, which holds the timing at slot 0. It then counts cycles to place a write inside slot 1 and compares every pin on every cycle across the boundary against a cycle-level model. Blanking that starts in the middle of a frame and line handover to the port are reached in the same way, starting from a known slot.

// File: rtl/lcd_hd_pkg.sv
package lcd_hd_pkg;

    typedef enum logic [1:0] {
        LVL_GND  = 2'b00,
        LVL_HALF = 2'b01,
        LVL_VDD  = 2'b10
    } lcd_lvl_e;

    // Slot index viewed as {polarity, plane}; counting up walks the frame order.
    typedef struct packed {
        logic neg;
        logic plane;
    } lcd_phase_t;

    localparam int SLOTS_PER_FRAME = 4;

    function automatic lcd_lvl_e lvl_flip(input lcd_lvl_e l);
        return (l == LVL_VDD) ? LVL_GND : LVL_VDD;
    endfunction

    function automatic lcd_lvl_e sel_level(input logic neg);
        return neg ? LVL_GND : LVL_VDD;
    endfunction

    function automatic lcd_lvl_e com_level(input logic selected, input logic neg);
        return selected ? sel_level(neg) : LVL_HALF;
    endfunction

    function automatic lcd_lvl_e seg_level(input logic lit, input logic neg);
        return lit ? lvl_flip(sel_level(neg)) : sel_level(neg);
    endfunction

endpackage

// File: rtl/lcd_hd_timebase.sv
module lcd_hd_timebase
    import lcd_hd_pkg::*;
#(
    parameter int SLOT_CLKS = 20000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hold,
    output lcd_phase_t phase,
    output logic       slot_end,
    output logic       frame_end
);
    localparam int CW = (SLOT_CLKS > 2) ? $clog2(SLOT_CLKS) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(SLOT_CLKS - 1);

    logic [CW-1:0] cnt;

    assign slot_end  = (cnt == CNT_LAST);
    assign frame_end = slot_end && phase.neg && phase.plane;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt   <= '0;
            phase <= '0;
        end else if (slot_end) begin
            cnt   <= '0;
            phase <= lcd_phase_t'(phase + 2'd1);
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/lcd_hd_planebuf.sv
module lcd_hd_planebuf #(
    parameter int WIDTH = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             load,
    output logic [WIDTH-1:0] shown
);
    logic [WIDTH-1:0] shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            shown  <= '0;
        end else begin
            if (load) shown  <= shadow;
            if (wr)   shadow <= wdata;
        end
    end

endmodule

// File: rtl/lcd_hd_pindrv.sv
module lcd_hd_pindrv
    import lcd_hd_pkg::*;
#(
    parameter int NUM_SEG    = 25,
    parameter int NUM_SHARED = 5
) (
    input  lcd_phase_t              phase,
    input  logic                    blank,
    input  logic [NUM_SEG-1:0]      bits_p1,
    input  logic [NUM_SEG-1:0]      bits_p2,
    input  logic [NUM_SHARED-1:0]   port_sel,
    input  logic [NUM_SHARED-1:0]   port_dout,
    output logic [3:0]              com_lvl,
    output logic [2*NUM_SEG-1:0]    seg_lvl
);
    localparam int SHARE_BASE = NUM_SEG - NUM_SHARED;

    lcd_lvl_e com1_l, com2_l;

    always_comb begin
        com1_l = com_level(!phase.plane, phase.neg);
        com2_l = com_level(phase.plane, phase.neg);
        if (blank) begin
            com1_l = LVL_GND;
            com2_l = LVL_GND;
        end
    end

    assign com_lvl = {com2_l, com1_l};

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_line
        logic     lit;
        lcd_lvl_e drv;
        lcd_lvl_e pin;

        assign lit = phase.plane ? bits_p2[g] : bits_p1[g];
        assign drv = seg_level(lit, phase.neg);

        if (g >= SHARE_BASE) begin : g_shared
            always_comb begin
                pin = drv;
                if (port_sel[g-SHARE_BASE])
                    pin = port_dout[g-SHARE_BASE] ? LVL_VDD : LVL_GND;
                if (blank)
                    pin = LVL_GND;
            end
        end else begin : g_plain
            assign pin = blank ? LVL_GND : drv;
        end

        assign seg_lvl[2*g +: 2] = pin;
    end

endmodule

// File: rtl/lcd_half_duty_drv.sv
module lcd_half_duty_drv
    import lcd_hd_pkg::*;
#(
    parameter int NUM_SEG    = 25,
    parameter int NUM_SHARED = 5,
    parameter int SLOT_CLKS  = 20000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  disp_off,
    input  logic                  clk_stop,
    input  logic                  wr_plane1,
    input  logic                  wr_plane2,
    input  logic [NUM_SEG-1:0]    wr_data,
    input  logic [NUM_SHARED-1:0] port_sel,
    input  logic [NUM_SHARED-1:0] port_dout,
    output logic [3:0]            com_lvl,
    output logic [2*NUM_SEG-1:0]  seg_lvl
);
    logic             hold;
    logic             blank;
    lcd_phase_t       phase;
    logic             slot_end;
    logic             frame_end;
    logic             take_new;
    logic [NUM_SEG-1:0] act_p1, act_p2;

    assign hold     = disp_off | clk_stop;
    assign blank    = rst | hold;
    assign take_new = frame_end | hold;

    lcd_hd_timebase #(.SLOT_CLKS(SLOT_CLKS)) u_tb (
        .clk(clk), .rst(rst), .hold(hold),
        .phase(phase), .slot_end(slot_end), .frame_end(frame_end)
    );

    lcd_hd_planebuf #(.WIDTH(NUM_SEG)) u_buf1 (
        .clk(clk), .rst(rst), .wr(wr_plane1), .wdata(wr_data),
        .load(take_new), .shown(act_p1)
    );

    lcd_hd_planebuf #(.WIDTH(NUM_SEG)) u_buf2 (
        .clk(clk), .rst(rst), .wr(wr_plane2), .wdata(wr_data),
        .load(take_new), .shown(act_p2)
    );

    lcd_hd_pindrv #(.NUM_SEG(NUM_SEG), .NUM_SHARED(NUM_SHARED)) u_pins (
        .phase(phase), .blank(blank), .bits_p1(act_p1), .bits_p2(act_p2),
        .port_sel(port_sel), .port_dout(port_dout),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

endmodule

// File: rtl/lcd_hd_chk.sv
module lcd_hd_chk
    import lcd_hd_pkg::*;
#(
    parameter int NUM_SEG    = 25,
    parameter int NUM_SHARED = 5
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  disp_off,
    input logic                  clk_stop,
    input logic [NUM_SHARED-1:0] port_sel,
    input logic [NUM_SHARED-1:0] port_dout,
    input logic [3:0]            com_lvl,
    input logic [2*NUM_SEG-1:0]  seg_lvl,
    input logic [1:0]            phase_bits,
    input logic                  slot_end,
    input logic                  frame_end,
    input logic [NUM_SEG-1:0]    act_p1,
    input logic [NUM_SEG-1:0]    act_p2
);
    localparam int SHARE_BASE = NUM_SEG - NUM_SHARED;

    logic hold;
    logic bad_code;
    assign hold = disp_off | clk_stop;

    always_comb begin
        bad_code = (com_lvl[1:0] == 2'b11) || (com_lvl[3:2] == 2'b11);
        for (int i = 0; i < NUM_SEG; i++)
            if (seg_lvl[2*i +: 2] == 2'b11) bad_code = 1'b1;
    end

    // R2
    no_illegal_code_chk: assert property (@(posedge clk) disable iff (rst) !bad_code);

    // R1
    reset_exit_slot0_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst) && !hold) |-> (com_lvl == {LVL_HALF, LVL_VDD}));

    // R8
    disp_off_blank_chk: assert property (@(posedge clk) disable iff (rst)
        disp_off |-> (com_lvl == '0 && seg_lvl == '0));

    // R9
    clk_stop_blank_chk: assert property (@(posedge clk) disable iff (rst)
        clk_stop |-> (com_lvl == '0 && seg_lvl == '0));

    // R4
    one_common_selected_chk: assert property (@(posedge clk) disable iff (rst)
        !hold |-> ((com_lvl[1:0] == LVL_HALF) != (com_lvl[3:2] == LVL_HALF)));

    // R3
    slot_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_end && !hold) |=> (phase_bits == 2'($past(phase_bits) + 2'd1)));

    // R3
    slot_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (!slot_end && !hold) |=> $stable(phase_bits));

    // R7
    plane1_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (act_p1 != $past(act_p1)) |-> ($past(frame_end) || $past(hold)));

    // R7
    plane2_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (act_p2 != $past(act_p2)) |-> ($past(frame_end) || $past(hold)));

    for (genvar j = 0; j < NUM_SHARED; j++) begin : g_port
        // R10
        port_line_chk: assert property (@(posedge clk) disable iff (rst)
            (!hold && port_sel[j]) |->
            (seg_lvl[2*(SHARE_BASE+j) +: 2] == (port_dout[j] ? LVL_VDD : LVL_GND)));
    end

endmodule

bind lcd_half_duty_drv lcd_hd_chk #(.NUM_SEG(NUM_SEG), .NUM_SHARED(NUM_SHARED)) u_chk (
    .clk(clk), .rst(rst), .disp_off(disp_off), .clk_stop(clk_stop),
    .port_sel(port_sel), .port_dout(port_dout),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl),
    .phase_bits(phase), .slot_end(slot_end), .frame_end(frame_end),
    .act_p1(act_p1), .act_p2(act_p2)
);

// File: tb/lcd_half_duty_drv_bench.sv
`timescale 1ns/1ps
module lcd_half_duty_drv_bench;
    localparam int N  = 25;
    localparam int SH = 5;
    localparam int S  = 4;
    localparam int BASE = N - SH;
    localparam logic [1:0] C_GND = 2'b00, C_HALF = 2'b01, C_VDD = 2'b10;

    logic clk = 1'b0;
    logic rst, disp_off, clk_stop, wr_plane1, wr_plane2;
    logic [N-1:0]  wr_data;
    logic [SH-1:0] port_sel, port_dout;
    logic [3:0]    com_lvl;
    logic [2*N-1:0] seg_lvl;

    int vectors = 0;
    int miscompares = 0;

    int m_cnt, m_slot;
    logic [N-1:0] m_sh1, m_sh2, m_act1, m_act2;

    always #2 clk = ~clk;

    lcd_half_duty_drv #(.NUM_SEG(N), .NUM_SHARED(SH), .SLOT_CLKS(S)) u_lcd_half_duty_drv (
        .clk(clk), .rst(rst), .disp_off(disp_off), .clk_stop(clk_stop),
        .wr_plane1(wr_plane1), .wr_plane2(wr_plane2), .wr_data(wr_data),
        .port_sel(port_sel), .port_dout(port_dout),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    function automatic logic [1:0] sel_l(input logic neg);
        return neg ? C_GND : C_VDD;
    endfunction

    task automatic check(input string tag);
        logic blk;
        logic [3:0] ec;
        logic [2*N-1:0] es;
        logic plane, neg;
        blk   = rst | disp_off | clk_stop;
        plane = m_slot[0];
        neg   = m_slot[1];
        ec = blk ? 4'b0 : (plane ? {sel_l(neg), C_HALF} : {C_HALF, sel_l(neg)});
        for (int i = 0; i < N; i++) begin
            logic lit;
            logic [1:0] l;
            lit = plane ? m_act2[i] : m_act1[i];
            l = lit ? sel_l(!neg) : sel_l(neg);
            if (i >= BASE && port_sel[i-BASE]) l = port_dout[i-BASE] ? C_VDD : C_GND;
            if (blk) l = C_GND;
            es[2*i +: 2] = l;
        end
        vectors++;
        if (com_lvl !== ec || seg_lvl !== es) begin
            miscompares++;
            $display("FAIL %s slot=%0d cnt=%0d: com act=%b exp=%b seg act=%h exp=%h",
                     tag, m_slot, m_cnt, com_lvl, ec, seg_lvl, es);
        end
    endtask

    task automatic tick(input string tag);
        logic blk, fend;
        @(posedge clk);
        if (rst) begin
            m_cnt = 0; m_slot = 0;
            m_sh1 = '0; m_sh2 = '0; m_act1 = '0; m_act2 = '0;
        end else begin
            blk  = disp_off | clk_stop;
            fend = (m_cnt == S-1) && (m_slot == 3);
            if (blk || fend) begin m_act1 = m_sh1; m_act2 = m_sh2; end
            if (blk) begin m_cnt = 0; m_slot = 0; end
            else if (m_cnt == S-1) begin m_cnt = 0; m_slot = (m_slot + 1) % 4; end
            else m_cnt++;
            if (wr_plane1) m_sh1 = wr_data;
            if (wr_plane2) m_sh2 = wr_data;
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic write_plane(input int p, input logic [N-1:0] d, input string tag);
        wr_data = d;
        if (p == 1) wr_plane1 = 1'b1; else wr_plane2 = 1'b1;
        tick(tag);
        wr_plane1 = 1'b0;
        wr_plane2 = 1'b0;
    endtask

    // R1: reset forces ground and restarts at slot 0
    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick("R1");
        rst = 1'b0;
        repeat (6) tick("R1");
    endtask

    // R3 R4 R5: bitmaps loaded while blanked, then two frames walked
    task automatic t_walk(input logic [N-1:0] d1, input logic [N-1:0] d2, input string tag);
        disp_off = 1'b1;
        write_plane(1, d1, "R8");
        write_plane(2, d2, "R8");
        tick("R8");
        disp_off = 1'b0;
        repeat (8*S) tick(tag);
    endtask

    // R6: a plane-2 write leaves plane 1 as it was
    task automatic t_separate();
        repeat (S) tick("R6");
        write_plane(2, 25'h0F0F0F0, "R6");
        repeat (10*S) tick("R6");
    endtask

    // R7: a write in mid-frame shows only after the next frame boundary
    task automatic t_double_buffer();
        disp_off = 1'b1; tick("R7"); disp_off = 1'b0;
        repeat (S + 1) tick("R7");
        write_plane(1, 25'h1555555, "R7");
        repeat (4*S) tick("R7");
        write_plane(2, 25'h0AAAAAA, "R7");
        repeat (8*S) tick("R7");
    endtask

    // R8: display off in mid-frame blanks, holds timing, takes latest data
    task automatic t_disp_off();
        repeat (2*S + 1) tick("R8");
        disp_off = 1'b1;
        write_plane(1, 25'h1234567, "R8");
        repeat (3) tick("R8");
        disp_off = 1'b0;
        repeat (5*S) tick("R8");
    endtask

    // R9: clock stop behaves as display off
    task automatic t_clk_stop();
        repeat (3*S + 2) tick("R9");
        clk_stop = 1'b1;
        write_plane(2, 25'h0C3C3C3, "R9");
        repeat (4) tick("R9");
        clk_stop = 1'b0;
        repeat (5*S) tick("R9");
    endtask

    // R10: handed-over top lines follow the port data, then blank
    task automatic t_port();
        port_sel = 5'b10101;
        port_dout = 5'b00100;
        repeat (4*S) tick("R10");
        port_dout = 5'b10001;
        port_sel = 5'b11111;
        repeat (4*S) tick("R10");
        disp_off = 1'b1;
        repeat (3) tick("R10");
        disp_off = 1'b0;
        port_sel = '0;
        repeat (4*S) tick("R10");
    endtask

    initial begin
        #(200000 * 4);
        miscompares++;
        $display("FAIL watchdog: run hung, actual=not finished expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst = 1'b1; disp_off = 1'b0; clk_stop = 1'b0;
        wr_plane1 = 1'b0; wr_plane2 = 1'b0; wr_data = '0;
        port_sel = '0; port_dout = '0;
        m_cnt = 0; m_slot = 0;
        m_sh1 = '0; m_sh2 = '0; m_act1 = '0; m_act2 = '0;
        t_reset();
        t_walk(25'h1555555, 25'h0AAAAAA, "R5");
        t_walk('1, '0, "R4");
        t_walk(25'h0000001, 25'h1000000, "R3");
        t_separate();
        t_double_buffer();
        t_disp_off();
        t_clk_stop();
        t_port();
        t_reset();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule